// File: doc/BRIEF.md
# Charge-Balanced Pixel Drive Sequencer

This block produces the electrode phasing for an array of bistable liquid-crystal pixels. It keeps the net voltage across every pixel at zero over time. A single drive clock feeds two places. The first is the shared cover electrode. The second is one input of an XOR at every pixel, whose other input is the pixel's stored bit. During the active half of a drive period the drive clock is low, so each pixel is driven with its stored bit. During the balancing half the clock is high, so each pixel sees the inverse of that voltage. Over a whole period every pixel therefore carries as much negative drive as positive drive, and this holds for any image. No separate inversion path is needed for the data.

A row loader hands over a complete frame by pulsing a frame strobe while the data is on the pixel input. The sequencer holds that frame as pending and shows it from the start of the next drive period. Each image therefore gets a complete, balanced period of its own. A mode input picks how the valid-image flag behaves. In chevron operation the image is valid only in the active half, and the array is treated as dark in the balancing half. In bistable operation the flag drops only for a short settling window after each drive-clock transition, which gives a duty cycle well above 90%. The drive period is set by a parameter. With a 24 MHz clock and a half length of 4000 cycles, one frame per period gives 3 kHz updates.

Top module: `pixDriveSeq`

## Requirements
- R1: Each bit of `pixOut` always equals the corresponding bit of the frame being shown, XORed with `comOut`.
- R2: `comOut` is the drive clock. It is low for `HALF_CYC` cycles (the active half) and then high for `HALF_CYC` cycles (the balancing half), and it starts low right after reset.
- R3: For every pixel, the sum of (`pixOut[i]` − `comOut`) taken over each complete drive period of 2·`HALF_CYC` cycles is zero, whatever data is shown.
- R4: A frame strobe captures `pixIn` as the pending frame. The pending frame is shown from the first active cycle of the next drive period, and never part-way through a period. If several strobes fall in one period, the last one wins. A strobe in the final cycle of a period appears one period later.
- R5: Reset is asynchronous and active low. While it is asserted, and in the first period after release, the shown frame is all zeros and the mode is chevron: `pixOut`=0, `comOut`=0 and `validOut`=1 at release.
- R6: With mode 0 (chevron), `validOut` is the inverse of `comOut`, so the image is valid for exactly half of each period.
- R7: With mode 1 (bistable), `validOut` is low only during the first `blankCyc` cycles of each half and high for the rest. With `blankCyc`=1 and `HALF_CYC`=16, it is valid for 30 of 32 cycles.
- R8: `modeSel` and `blankCyc` are sampled only at the boundary into a new drive period. Changing them inside a period has no effect until the next period.
- R9: A new frame can be applied in every drive period of 2·`HALF_CYC` cycles, so successive strobes, one per period, appear in successive periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | NUM_PIX | Frame data from the row loader |
| frameStrobe | input | 1 | Captures `pixIn` as the pending frame |
| modeSel | input | 1 | 0 = chevron operation, 1 = bistable operation |
| blankCyc | input | BLANK_W | Settling window length for bistable mode |
| pixOut | output | NUM_PIX | Per-pixel electrode levels |
| comOut | output | 1 | Common electrode level, which is the drive clock |
| validOut | output | 1 | High while the displayed image is valid |

## Verification
The checker watches several properties on every cycle. It confirms that the drive clock's halves each last exactly `HALF_CYC` cycles, and that each pixel's signed drive sums to zero over every period. It confirms that the pixel pattern relative to the common electrode changes only at a period boundary, that the latched mode changes only there, and that chevron validity tracks the inverse drive clock. Other behaviour depends on data and timing the checker does not know, so only the bench's scenarios can show it. That covers which frame a strobe lands in (including strobes in the last cycle and several strobes in one period), the exact bistable settling window for each `blankCyc`, the duty-cycle figures, and the reset-state contents.

// File: rtl/pixDrivePkg.sv
package pixDrivePkg;

  typedef enum logic {
    MODE_CHEVRON  = 1'b0,
    MODE_BISTABLE = 1'b1
  } dispMode_t;

  // strobes from the phase controller to the pixel datapath
  typedef struct packed {
    logic loadFrame;  // last cycle of a period: pending frame moves to shown
    logic driveClk;   // global drive clock, high in the balancing half
  } drvStrobe_t;

endpackage

// File: rtl/pixPhaseCtrl.sv
module pixPhaseCtrl
  import pixDrivePkg::*;
#(
  parameter int HALF_CYC = 16,
  parameter int BLANK_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic [BLANK_W-1:0] blankCyc,
  output drvStrobe_t         strobes,
  output logic               validImg,
  output logic               bistableMode
);

  localparam int PERIOD = 2 * HALF_CYC;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int CMP_W  = ((CNT_W > BLANK_W) ? CNT_W : BLANK_W) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF_CYC);

  logic [CNT_W-1:0]   phaseCnt;
  dispMode_t          modeLatched;
  logic [BLANK_W-1:0] blankLatched;
  logic               lastCyc;
  logic               inBalance;
  logic [CNT_W-1:0]   halfPos;

  assign lastCyc   = (phaseCnt == LAST_CNT);
  assign inBalance = (phaseCnt >= HALF_CNT);
  assign halfPos   = inBalance ? (phaseCnt - HALF_CNT) : phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt     <= '0;
      modeLatched  <= MODE_CHEVRON;
      blankLatched <= '0;
    end else begin
      phaseCnt <= lastCyc ? '0 : phaseCnt + 1'b1;
      if (lastCyc) begin
        modeLatched  <= dispMode_t'(modeSel);
        blankLatched <= blankCyc;
      end
    end
  end

  always_comb begin
    strobes.loadFrame = lastCyc;
    strobes.driveClk  = inBalance;
    if (modeLatched == MODE_BISTABLE)
      validImg = (CMP_W'(halfPos) >= CMP_W'(blankLatched));
    else
      validImg = !inBalance;
  end

  assign bistableMode = (modeLatched == MODE_BISTABLE);

endmodule

// File: rtl/pixDriveDatapath.sv
module pixDriveDatapath
  import pixDrivePkg::*;
#(
  parameter int NUM_PIX = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] pixIn,
  input  logic               frameStrobe,
  input  drvStrobe_t         strobes,
  output logic [NUM_PIX-1:0] pixOut,
  output logic               comOut
);

  logic [NUM_PIX-1:0] pendingFrame;
  logic [NUM_PIX-1:0] shownFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingFrame <= '0;
      shownFrame   <= '0;
    end else begin
      if (frameStrobe) pendingFrame <= pixIn;
      if (strobes.loadFrame) shownFrame <= pendingFrame;
    end
  end

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pixXor
    assign pixOut[p] = shownFrame[p] ^ strobes.driveClk;
  end

  assign comOut = strobes.driveClk;

endmodule

// File: rtl/pixDriveSeq.sv
module pixDriveSeq
  import pixDrivePkg::*;
#(
  parameter int NUM_PIX  = 8,
  parameter int HALF_CYC = 16,
  parameter int BLANK_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] pixIn,
  input  logic               frameStrobe,
  input  logic               modeSel,
  input  logic [BLANK_W-1:0] blankCyc,
  output logic [NUM_PIX-1:0] pixOut,
  output logic               comOut,
  output logic               validOut
);

  drvStrobe_t ctrlStrobes;
  logic       modeIsBistable;

  pixPhaseCtrl #(.HALF_CYC(HALF_CYC), .BLANK_W(BLANK_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .blankCyc     (blankCyc),
    .strobes      (ctrlStrobes),
    .validImg     (validOut),
    .bistableMode (modeIsBistable)
  );

  pixDriveDatapath #(.NUM_PIX(NUM_PIX)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pixIn       (pixIn),
    .frameStrobe (frameStrobe),
    .strobes     (ctrlStrobes),
    .pixOut      (pixOut),
    .comOut      (comOut)
  );

endmodule

// File: rtl/pixDriveChecker.sv
module pixDriveChecker #(
  parameter int NUM_PIX  = 8,
  parameter int HALF_CYC = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_PIX-1:0] pixOut,
  input logic               comOut,
  input logic               validOut,
  input logic               bistableMode
);

  localparam int RUN_W = $clog2(HALF_CYC + 1) + 1;
  localparam int ACC_W = $clog2(2 * HALF_CYC) + 2;

  logic             prevCom;
  logic             armed;
  logic [RUN_W-1:0] runLen;
  logic             newPeriod;

  assign newPeriod = prevCom && !comOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCom <= 1'b0;
      armed   <= 1'b0;
      runLen  <= '0;
    end else begin
      prevCom <= comOut;
      armed   <= 1'b1;
      runLen  <= (comOut != prevCom) ? RUN_W'(1) : runLen + 1'b1;
    end
  end

  // R2: each drive-clock level lasts exactly HALF_CYC cycles
  assert_half_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (comOut != prevCom) |-> (runLen == RUN_W'(HALF_CYC)));

  assert_max_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= RUN_W'(HALF_CYC));

  // R1, R4: the pixel pattern relative to the common electrode changes only at a period boundary
  assert_frame_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !newPeriod) |-> $stable(pixOut ^ {NUM_PIX{comOut}}));

  // R8: the latched mode changes only at a period boundary
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !newPeriod) |-> $stable(bistableMode));

  // R6: chevron validity follows the active half
  assert_chevron_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !bistableMode |-> (validOut == !comOut));

  // R3: net drive per pixel is zero over every period
  for (genvar p = 0; p < NUM_PIX; p++) begin : g_bal
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] stepVal;

    always_comb begin
      if (pixOut[p] == comOut) stepVal = '0;
      else if (pixOut[p])      stepVal = ACC_W'(1);
      else                     stepVal = {ACC_W{1'b1}};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          acc <= '0;
      else if (newPeriod) acc <= stepVal;
      else                acc <= acc + stepVal;
    end

    assert_zero_net_R3: assert property (@(posedge clk) disable iff (!rstN)
      newPeriod |-> (acc == '0));
  end

endmodule

bind pixDriveSeq pixDriveChecker #(.NUM_PIX(NUM_PIX), .HALF_CYC(HALF_CYC)) u_pixDriveChecker (
  .clk          (clk),
  .rstN         (rstN),
  .pixOut       (pixOut),
  .comOut       (comOut),
  .validOut     (validOut),
  .bistableMode (modeIsBistable)
);

// File: tb/pixDriveSeq_bench.sv
module pixDriveSeq_bench;

  localparam int CLK_P = 10;
  localparam int NP    = 8;
  localparam int HALF  = 16;
  localparam int BW    = 4;
  localparam int NVEC  = 8;

  // entry: {frame data, mode, blank cycles}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'hA5, 1'b0, 4'd0},
    {8'hFF, 1'b1, 4'd1},
    {8'h00, 1'b1, 4'd3},
    {8'h3C, 1'b1, 4'd0},
    {8'h81, 1'b0, 4'd2},
    {8'h5A, 1'b1, 4'd15},
    {8'hFF, 1'b0, 4'd0},
    {8'h0F, 1'b1, 4'd2}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] pixIn;
  logic          frameStrobe;
  logic          modeSel;
  logic [BW-1:0] blankCyc;
  logic [NP-1:0] pixOut;
  logic          comOut;
  logic          validOut;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  pixDriveSeq #(.NUM_PIX(NP), .HALF_CYC(HALF), .BLANK_W(BW)) u_pixDriveSeq (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .frameStrobe(frameStrobe),
    .modeSel(modeSel), .blankCyc(blankCyc),
    .pixOut(pixOut), .comOut(comOut), .validOut(validOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runPeriod(input string tag, input logic [NP-1:0] expData,
                           input logic expMode, input logic [BW-1:0] expBlank,
                           input int stbA, input logic [NP-1:0] dA,
                           input int stbB, input logic [NP-1:0] dB,
                           input logic nxtMode, input logic [BW-1:0] nxtBlank,
                           output int vCnt);
    int bal [NP];
    for (int i = 0; i < NP; i++) bal[i] = 0;
    vCnt = 0;
    for (int c = 0; c < 2 * HALF; c++) begin
      logic          eCom;
      int            pos;
      logic [NP-1:0] ePix;
      logic          eValid;
      eCom   = (c >= HALF);
      pos    = eCom ? c - HALF : c;
      ePix   = expData ^ {NP{eCom}};
      eValid = expMode ? (pos >= int'(expBlank)) : !eCom;
      chk(pixOut === ePix, {"R1 ", tag}, "pixel levels", 32'(pixOut), 32'(ePix));
      chk(comOut === eCom, "R2", "common level", 32'(comOut), 32'(eCom));
      chk(validOut === eValid, expMode ? {"R7 ", tag} : {"R6 ", tag},
          "valid flag", 32'(validOut), 32'(eValid));
      if (validOut) vCnt++;
      for (int i = 0; i < NP; i++) bal[i] += int'(pixOut[i]) - int'(comOut);
      frameStrobe = (c == stbA) || (c == stbB);
      pixIn       = (c == stbB) ? dB : dA;
      if (c == HALF) begin  // R8: mid-period change of mode inputs
        modeSel  = nxtMode;
        blankCyc = nxtBlank;
      end
      step();
    end
    frameStrobe = 1'b0;
    for (int i = 0; i < NP; i++)
      chk(bal[i] == 0, "R3", "net pixel drive", 32'(bal[i]), 32'd0);
  endtask

  initial begin
    int            vc;
    logic [NP-1:0] prevData;
    logic          prevMode;
    logic [BW-1:0] prevBlank;

    rstN = 1'b0; pixIn = '0; frameStrobe = 1'b0; modeSel = 1'b0; blankCyc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(pixOut === '0, "R5", "reset pixels", 32'(pixOut), 32'd0);
    chk(comOut === 1'b0, "R5", "reset common", 32'(comOut), 32'd0);
    chk(validOut === 1'b1, "R5", "reset valid", 32'(validOut), 32'd1);

    // table walk: one new frame per period (R9), mode inputs changed mid-period (R8)
    prevData = '0; prevMode = 1'b0; prevBlank = '0;
    for (int e = 0; e < NVEC; e++) begin
      logic [NP-1:0] d;
      logic          m;
      logic [BW-1:0] b;
      {d, m, b} = VEC[e];
      runPeriod("R9", prevData, prevMode, prevBlank, 0, d, -1, d, m, b, vc);
      if (!prevMode) chk(vc == HALF, "R6", "chevron duty count", 32'(vc), 32'(HALF));
      prevData = d; prevMode = m; prevBlank = b;
    end

    // R4: strobe in the final cycle lands one period later
    runPeriod("R4", prevData, prevMode, prevBlank, 2 * HALF - 1, 8'hC3, -1, 8'hC3,
              1'b1, 4'd1, vc);
    chk(vc == 28, "R7", "bistable duty blank2", 32'(vc), 32'd28);
    runPeriod("R4", prevData, 1'b1, 4'd1, -1, 8'h00, -1, 8'h00, 1'b1, 4'd1, vc);
    chk(vc * 10 > 9 * 2 * HALF, "R7", "bistable duty above 90%", 32'(vc), 32'd30);
    // R4: two strobes in one period, the last wins
    runPeriod("R4", 8'hC3, 1'b1, 4'd1, 2, 8'h11, 5, 8'h22, 1'b0, 4'd0, vc);
    runPeriod("R4", 8'h22, 1'b0, 4'd0, -1, 8'h00, -1, 8'h00, 1'b1, 4'd3, vc);
    chk(vc == HALF, "R6", "chevron duty count", 32'(vc), 32'(HALF));

    // R5: reset mid-period, with bistable mode requested during reset
    repeat (5) step();
    modeSel = 1'b1; blankCyc = 4'd2;
    rstN = 1'b0;
    #1;
    chk(pixOut === '0, "R5", "pixels in reset", 32'(pixOut), 32'd0);
    chk(comOut === 1'b0, "R5", "common in reset", 32'(comOut), 32'd0);
    chk(validOut === 1'b1, "R5", "valid in reset", 32'(validOut), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    runPeriod("R5", 8'h00, 1'b0, 4'd0, -1, 8'h00, -1, 8'h00, 1'b1, 4'd2, vc);
    runPeriod("R8", 8'h00, 1'b1, 4'd2, -1, 8'h00, -1, 8'h00, 1'b1, 4'd2, vc);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule